// File: doc/BRIEF.md
# Two-Bit Signaling-Channel Serial Capture Buffer

This block collects the slow serial signaling bits of a burst transceiver on the master side. Each serial lane supplies two bits per frame. The bits are sampled on falling edges of a data clock, and a frame reference marks the frame boundary. For every lane the block keeps a small buffer of the most recent samples. On each rising edge of the frame reference it copies all lane buffers at once into a parallel word for the burst assembler, and it raises a one-cycle strobe with the word.

The data clock, the frame reference, the lane data and the hold input all come from outside the block. All of them pass through one synchronizer of equal depth, so a data bit stays aligned with the clock edge that samples it. The edges are then found against the fast system clock. While the hold input is low, the lane buffers keep their contents and ignore clock edges. Frame transfers continue during hold and send the frozen contents.

Top module: `dchan_pair_buffer`

## Requirements
- R1: After reset, `word_o` is 0 and `word_vld_o` is 0.
- R2: The first synchronized falling edge of `sdclk_i` after a rising edge of `frame_i` stores the lane bit in the more significant position of that lane's field.
- R3: The second falling edge in the same frame stores the lane bit in the less significant position of the field.
- R4: Each further falling edge in the same frame shifts the field up by one. The oldest bit is dropped and the new bit enters the less significant position, so the field always holds the latest two samples.
- R5: On each rising edge of `frame_i`, the buffered fields are copied to `word_o`. `word_vld_o` is high for exactly one system clock with the new word and is never high otherwise.
- R6: When a frame has fewer than two falling edges, any position that was not written in that frame keeps its value from before.
- R7: While `hold_n_i` is low, falling edges of `sdclk_i` leave the buffers unchanged. A frame transfer during hold still sends the held contents.
- R8: `word_o[3:2]` holds lane `din_i[1]` and `word_o[1:0]` holds lane `din_i[0]`. Between strobes, `word_o` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sdclk_i |
| rst_n | input | 1 | Asynchronous active-low reset |
| sdclk_i | input | 1 | Serial data clock; bits are sampled on its falling edge |
| frame_i | input | 1 | Frame reference; a rising edge marks the frame boundary |
| hold_n_i | input | 1 | Low freezes the lane buffers |
| din_i | input | 2 | Serial lane data, one bit per lane |
| word_o | output | 4 | Transferred word, two bits per lane, first sample in the upper bit |
| word_vld_o | output | 1 | One-cycle strobe, high with each new word |

## Verification
The bench runs frames with zero, one, two, three and five data-clock edges. A design that shifts without a per-frame edge count puts the previous frame's second bit on top after a single edge. A design that counts a fixed number of edges stops shifting after two edges and keeps bits that should have been dropped. Hold windows placed across sampled edges catch a buffer that keeps capturing while hold is low, and a transfer made during hold catches a design that drops the word. A scoreboard built from the requirements checks each strobe and its word, and flags a strobe that lasts two cycles or that never arrives.

// File: rtl/dcb_pkg.sv
package dcb_pkg;
  // default geometry of the signaling capture
  localparam int unsigned DEF_LANES = 2;
  localparam int unsigned DEF_BITS  = 2;
  localparam int unsigned DEF_SYNC  = 2;
endpackage

// File: rtl/dcb_sync.sv
module dcb_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= d_i;
      for (int i = 1; i < int'(STAGES); i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/dcb_edge.sv
module dcb_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~prev_q;
  assign fall_o = ~lvl_i & prev_q;
endmodule

// File: rtl/dcb_lane.sv
module dcb_lane #(
  parameter int unsigned BITS = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            frame_rise_i,
  input  logic            sample_en_i,
  input  logic            bit_i,
  output logic [BITS-1:0] buf_o
);
  localparam int unsigned CW = $clog2(BITS + 1);

  logic [BITS-1:0] buf_q, buf_d;
  logic [CW-1:0]   cnt_q, cnt_d, cnt_eff;
  logic            buf_en, cnt_en;

  // a frame edge restarts the count; an edge in the same cycle is bit 0
  always_comb begin
    cnt_eff = frame_rise_i ? '0 : cnt_q;
    buf_d   = buf_q;
    cnt_d   = cnt_eff;
    if (sample_en_i) begin
      if (cnt_eff < CW'(BITS)) begin
        buf_d[BITS-1-int'(cnt_eff)] = bit_i;
        cnt_d = cnt_eff + 1'b1;
      end else begin
        buf_d = {buf_q, bit_i} >> 0;
        buf_d = (buf_q << 1) | {{(BITS-1){1'b0}}, bit_i};
      end
    end
  end

  assign buf_en = sample_en_i;
  assign cnt_en = sample_en_i | frame_rise_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_q <= '0;
      cnt_q <= '0;
    end else begin
      if (buf_en) buf_q <= buf_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign buf_o = buf_q;
endmodule

// File: rtl/dchan_pair_buffer.sv
module dchan_pair_buffer #(
  parameter int unsigned NUM_LANES     = dcb_pkg::DEF_LANES,
  parameter int unsigned BITS_PER_LANE = dcb_pkg::DEF_BITS,
  parameter int unsigned SYNC_STAGES   = dcb_pkg::DEF_SYNC
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               sdclk_i,
  input  logic                               frame_i,
  input  logic                               hold_n_i,
  input  logic [NUM_LANES-1:0]               din_i,
  output logic [NUM_LANES*BITS_PER_LANE-1:0] word_o,
  output logic                               word_vld_o
);
  localparam int unsigned WW = NUM_LANES * BITS_PER_LANE;
  localparam int unsigned SW = NUM_LANES + 3;

  logic [SW-1:0]        raw_in, sync_out;
  logic [NUM_LANES-1:0] din_s;
  logic                 sdclk_s, frame_s, hold_s;
  logic                 sd_fall, sd_rise_nc, frame_rise, frame_fall_nc;
  logic                 sample_en;
  logic [WW-1:0]        buf_flat;
  logic [WW-1:0]        word_q, word_d;
  logic                 vld_q, vld_d;

  // one synchronizer for all inputs keeps data aligned with its clock edge
  assign raw_in = {hold_n_i, frame_i, sdclk_i, din_i};

  dcb_sync #(.WIDTH(SW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(sync_out)
  );

  assign din_s   = sync_out[NUM_LANES-1:0];
  assign sdclk_s = sync_out[NUM_LANES];
  assign frame_s = sync_out[NUM_LANES+1];
  assign hold_s  = sync_out[NUM_LANES+2];

  dcb_edge u_sd_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(sdclk_s), .rise_o(sd_rise_nc), .fall_o(sd_fall)
  );

  dcb_edge u_fr_edge (
    .clk(clk), .rst_n(rst_n), .lvl_i(frame_s), .rise_o(frame_rise), .fall_o(frame_fall_nc)
  );

  assign sample_en = sd_fall & hold_s;

  for (genvar g = 0; g < int'(NUM_LANES); g++) begin : g_lane
    dcb_lane #(.BITS(BITS_PER_LANE)) u_lane (
      .clk         (clk),
      .rst_n       (rst_n),
      .frame_rise_i(frame_rise),
      .sample_en_i (sample_en),
      .bit_i       (din_s[g]),
      .buf_o       (buf_flat[g*BITS_PER_LANE +: BITS_PER_LANE])
    );
  end

  // transfer stage: takes the buffers as they were before this cycle's sample
  always_comb begin
    word_d = word_q;
    vld_d  = frame_rise;
    if (frame_rise) word_d = buf_flat;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      if (frame_rise) word_q <= word_d;
      vld_q <= vld_d;
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = vld_q;
endmodule

// File: rtl/dcb_chk.sv
module dcb_chk #(
  parameter int unsigned WW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          frame_rise,
  input logic          hold_s,
  input logic [WW-1:0] buf_flat,
  input logic [WW-1:0] word_o,
  input logic          word_vld_o
);
  a_r5_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    word_vld_o |=> !word_vld_o);

  a_r5_transfer_copies: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rise |=> (word_vld_o && word_o == $past(buf_flat)));

  a_r5_strobe_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_rise |=> !word_vld_o);

  a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    !hold_s |=> $stable(buf_flat));

  a_r8_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !word_vld_o |-> $stable(word_o));
endmodule

bind dchan_pair_buffer dcb_chk #(.WW(NUM_LANES*BITS_PER_LANE)) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_rise(frame_rise), .hold_s(hold_s),
  .buf_flat(buf_flat), .word_o(word_o), .word_vld_o(word_vld_o)
);

// File: tb/tb_dchan_pair_buffer.sv
module tb_dchan_pair_buffer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sdclk_i = 1'b1;
  logic       frame_i = 1'b0;
  logic       hold_n_i = 1'b1;
  logic [1:0] din_i = 2'b00;
  logic [3:0] word_o;
  logic       word_vld_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [3:0] exp_q[$];
  logic [1:0] mbuf [2];
  int         mcnt = 0;
  logic       prev_vld = 1'b0;

  always #2 clk = ~clk;

  dchan_pair_buffer dut (
    .clk(clk), .rst_n(rst_n), .sdclk_i(sdclk_i), .frame_i(frame_i),
    .hold_n_i(hold_n_i), .din_i(din_i), .word_o(word_o), .word_vld_o(word_vld_o)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one data-clock period; the model follows R2, R3, R4, R6, R7
  task automatic sd_bit(input logic [1:0] d);
    din_i = d;
    wait_cyc(3);
    sdclk_i = 1'b0;
    if (hold_n_i) begin
      for (int l = 0; l < 2; l++) begin
        if (mcnt < 2) mbuf[l][1-mcnt] = d[l];
        else          mbuf[l] = {mbuf[l][0], d[l]};
      end
      if (mcnt < 2) mcnt++;
    end
    wait_cyc(4);
    sdclk_i = 1'b1;
    wait_cyc(4);
  endtask

  // frame boundary: expected word is {lane1 field, lane0 field} (R5, R8)
  task automatic frame_edge();
    exp_q.push_back({mbuf[1], mbuf[0]});
    mcnt = 0;
    frame_i = 1'b1;
    wait_cyc(5);
    frame_i = 1'b0;
    wait_cyc(4);
  endtask

  // monitor: every strobe pops one expected word
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (word_vld_o && prev_vld) check("R5 strobe width", 4'd2, 4'd1);
      if (word_vld_o) begin
        if (exp_q.size() == 0) check("R5 unexpected strobe", word_o, 4'bxxxx);
        else check("R2/R3/R4/R6/R7/R8 word", word_o, exp_q.pop_front());
      end
      prev_vld <= word_vld_o;
    end
  end

  initial begin
    mbuf[0] = 2'b00;
    mbuf[1] = 2'b00;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R1 reset word", word_o, 4'b0000);
    check("R1 reset strobe", {3'b0, word_vld_o}, 4'b0000);

    // R2 R3: two edges, lane1 gets 1,0 and lane0 gets 0,1 -> 1001
    frame_edge();
    sd_bit(2'b10);
    sd_bit(2'b01);
    frame_edge();
    // R4: three edges keep the last two
    sd_bit(2'b11);
    sd_bit(2'b01);
    sd_bit(2'b10);
    frame_edge();
    // R6: one edge rewrites only the upper bit of each field
    sd_bit(2'b01);
    frame_edge();
    // R6: no edges resend the buffers unchanged
    frame_edge();
    // R7: hold over two edges, then one live edge
    hold_n_i = 1'b0;
    wait_cyc(4);
    sd_bit(2'b11);
    sd_bit(2'b00);
    hold_n_i = 1'b1;
    wait_cyc(4);
    sd_bit(2'b10);
    frame_edge();
    // R7: transfer during hold sends the frozen contents
    hold_n_i = 1'b0;
    wait_cyc(4);
    sd_bit(2'b11);
    frame_edge();
    hold_n_i = 1'b1;
    wait_cyc(4);
    // R4: five edges
    sd_bit(2'b00);
    sd_bit(2'b11);
    sd_bit(2'b01);
    sd_bit(2'b10);
    sd_bit(2'b11);
    frame_edge();
    // mixed patterns R2 R3 R4 R6
    for (int f = 0; f < 12; f++) begin
      int ne;
      ne = f % 4;
      for (int k = 0; k < ne; k++) sd_bit(2'($urandom_range(0, 3)));
      frame_edge();
    end
    wait_cyc(10);
    check("R5 all strobes seen", 4'(exp_q.size()), 4'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule